// File: doc/BRIEF.md
# Bit-Serial Logic Processor

This block applies a bitwise logical function to two operand words, working through them one bit position per clock. Each operand sits in its own right-shifting register, and each register is written from a shared data bus by its own load strobe. A rising edge on the execute input starts a fixed run whose length equals the operand width.

On every step of the run, the low bit of each register goes to a small logic unit, and a function code picks the operation. A routing multiplexer, steered by a select code, then decides which bit enters the top of each register on that shift. After the last step, every bit position has been processed exactly once and is back in its original place.

Depending on the select code, the result replaces operand A, replaces operand B, replaces both, or the two registers are exchanged. Operand A is always visible on the LED output, and a busy output marks the run.

Top module: `bitser_logic_top`

## Requirements
- R1: While rst_ni is low, and after it is released, led_o and busy_o are 0, and both registers hold 0.
- R2: While busy_o is low, load_a_i=1 writes data_i into register A, and load_b_i=1 writes data_i into register B, at the next clock edge. led_o always shows register A.
- R3: If exec_i is 1 at a clock edge, was 0 at the previous edge, and the block is idle, then busy_o rises after that edge and stays high for exactly W (default 8) cycles.
- R4: Changes on exec_i while busy_o is high are ignored. Holding exec_i high after a run does not start another run; exec_i must go low and then high again.
- R5: While busy_o is high, load_a_i and load_b_i are ignored, and the run result is unchanged by them.
- R6: Function code func_i picks the bit operation on (a, b): 000 AND, 001 OR, 010 XOR, 011 NAND, 100 NOR, 101 XNOR, 110 NOT a, 111 a.
- R7: Select code route_i sets the bits fed back as {into A, into B}: 00 {result, b}, 01 {a, result}, 10 {result, result}, 11 {b, a}.
- R8: Bits are processed from the least significant bit upwards. Each step shifts both registers right by one and inserts the routed bits at the top. After W steps, each register holds the bitwise word: for example, route 00 gives A = f(A,B) with B unchanged, and route 11 exchanges A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute request, acts on its rising edge |
| load_a_i | input | 1 | Write data_i into register A |
| load_b_i | input | 1 | Write data_i into register B |
| data_i | input | W | Operand data bus |
| func_i | input | 3 | Logical function code |
| route_i | input | 2 | Feedback routing select |
| led_o | output | W | Contents of register A |
| busy_o | output | 1 | High while a run is in progress |

## Verification
The assertions assume that func_i and route_i are held steady for the whole of a run. The bench meets this by setting both codes before it raises exec_i and changing them only after busy_o has fallen. No assertion depends on the load strobes being quiet during a run, so the bench pulses the strobes and toggles exec_i mid-run on purpose. Register B is not visible at the ports, so the bench reads it by starting a second run with the exchange select and then observing led_o.

// File: rtl/bitser_logic_pkg.sv
package bitser_logic_pkg;
  typedef enum logic [2:0] {
    FN_AND    = 3'b000,
    FN_OR     = 3'b001,
    FN_XOR    = 3'b010,
    FN_NAND   = 3'b011,
    FN_NOR    = 3'b100,
    FN_XNOR   = 3'b101,
    FN_NOT_A  = 3'b110,
    FN_PASS_A = 3'b111
  } func_e;

  typedef enum logic [1:0] {
    RT_INTO_A = 2'b00,
    RT_INTO_B = 2'b01,
    RT_BOTH   = 2'b10,
    RT_SWAP   = 2'b11
  } route_e;
endpackage

// File: rtl/bitser_seq.sv
module bitser_seq #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic exec_i,
  output logic busy_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          exec_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          start;

  assign start  = exec_i & ~exec_q & ~busy_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      exec_q <= exec_i;
      if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  // R3
  run_starts_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> cnt_q == '0);

  // R3
  run_ends_at_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == LAST);

  // R4
  run_not_cut_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != LAST) |=> busy_q);

  // R3
  idle_count_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> cnt_q == '0);
endmodule

// File: rtl/bitser_alu.sv
module bitser_alu
  import bitser_logic_pkg::*;
(
  input  func_e func_i,
  input  logic  a_i,
  input  logic  b_i,
  output logic  y_o
);
  always_comb begin
    unique case (func_i)
      FN_AND:    y_o = a_i & b_i;
      FN_OR:     y_o = a_i | b_i;
      FN_XOR:    y_o = a_i ^ b_i;
      FN_NAND:   y_o = ~(a_i & b_i);
      FN_NOR:    y_o = ~(a_i | b_i);
      FN_XNOR:   y_o = ~(a_i ^ b_i);
      FN_NOT_A:  y_o = ~a_i;
      default:   y_o = a_i;
    endcase
  end
endmodule

// File: rtl/bitser_router.sv
module bitser_router
  import bitser_logic_pkg::*;
(
  input  route_e route_i,
  input  logic   a_i,
  input  logic   b_i,
  input  logic   y_i,
  output logic   new_a_o,
  output logic   new_b_o
);
  always_comb begin
    unique case (route_i)
      RT_INTO_A: begin new_a_o = y_i; new_b_o = b_i; end
      RT_INTO_B: begin new_a_o = a_i; new_b_o = y_i; end
      RT_BOTH:   begin new_a_o = y_i; new_b_o = y_i; end
      default:   begin new_a_o = b_i; new_b_o = a_i; end
    endcase
  end
endmodule

// File: rtl/bitser_shreg.sv
module bitser_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (shift_i) q <= {ser_i, q[W-1:1]};
    else if (load_i)  q <= data_i;
  end

  assign q_o = q;

  // R2
  hold_when_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(q));
endmodule

// File: rtl/bitser_logic_top.sv
module bitser_logic_top
  import bitser_logic_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         exec_i,
  input  logic         load_a_i,
  input  logic         load_b_i,
  input  logic [W-1:0] data_i,
  input  logic [2:0]   func_i,
  input  logic [1:0]   route_i,
  output logic [W-1:0] led_o,
  output logic         busy_o
);
  logic         busy;
  logic [W-1:0] a_q, b_q;
  logic         y, new_a, new_b;

  bitser_seq #(.W(W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .exec_i (exec_i),
    .busy_o (busy)
  );

  bitser_alu u_alu (
    .func_i (func_e'(func_i)),
    .a_i    (a_q[0]),
    .b_i    (b_q[0]),
    .y_o    (y)
  );

  bitser_router u_router (
    .route_i (route_e'(route_i)),
    .a_i     (a_q[0]),
    .b_i     (b_q[0]),
    .y_i     (y),
    .new_a_o (new_a),
    .new_b_o (new_b)
  );

  // shift has priority in the register, so loads are dropped while busy
  bitser_shreg #(.W(W)) u_reg_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_a_i),
    .data_i  (data_i),
    .shift_i (busy),
    .ser_i   (new_a),
    .q_o     (a_q)
  );

  bitser_shreg #(.W(W)) u_reg_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_b_i),
    .data_i  (data_i),
    .shift_i (busy),
    .ser_i   (new_b),
    .q_o     (b_q)
  );

  assign led_o  = a_q;
  assign busy_o = busy;

  // R7
  both_routes_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_i == 2'b10) |-> new_a == new_b);

  // R7
  swap_crosses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_i == 2'b11) |-> (new_a == b_q[0] && new_b == a_q[0]));

  // R5
  load_blocked_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> led_o[W-2:0] == $past(a_q[W-1:1]));
endmodule

// File: tb/tb_bitser_logic_top.sv
module tb_bitser_logic_top;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         exec = 1'b0, ld_a = 1'b0, ld_b = 1'b0;
  logic [W-1:0] data = '0;
  logic [2:0]   func = '0;
  logic [1:0]   route = '0;
  logic [W-1:0] led;
  logic         busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bitser_logic_top #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .load_a_i(ld_a), .load_b_i(ld_b),
    .data_i(data), .func_i(func), .route_i(route), .led_o(led), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] op(logic [2:0] f, logic [W-1:0] a, logic [W-1:0] b);
    case (f)
      3'd0: return a & b;
      3'd1: return a | b;
      3'd2: return a ^ b;
      3'd3: return ~(a & b);
      3'd4: return ~(a | b);
      3'd5: return ~(a ^ b);
      3'd6: return ~a;
      default: return a;
    endcase
  endfunction

  task automatic load(logic which_b, logic [W-1:0] v);
    @(negedge clk);
    data = v; ld_a = !which_b; ld_b = which_b;
    @(negedge clk);
    ld_a = 0; ld_b = 0;
  endtask

  // one run; optionally disturb exec and loads mid-run
  task automatic run(logic [2:0] f, logic [1:0] r, bit disturb);
    @(negedge clk);
    func = f; route = r; exec = 1;
    for (int i = 1; i <= W; i++) begin
      @(negedge clk);
      if (i == 1) exec = 0;
      if (disturb && i == 3) begin exec = 1; ld_a = 1; ld_b = 1; data = 8'h3C; end
      if (disturb && i == 4) begin exec = 0; ld_a = 0; ld_b = 0; end
      if (disturb && i == 5) exec = 1;
      if (disturb && i == 6) exec = 0;
      checks++;
      if (busy !== 1'b1) begin
        errors++;
        $display("FAIL R3: busy actual %b expected 1 at step %0d", busy, i);
      end
    end
    @(negedge clk);
    chk(disturb ? "R4" : "R3", {7'd0, busy}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, ea, eb;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", led, '0);
    chk("R1", {7'd0, busy}, 8'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", led, '0);
    // R2: load A visible, load B not on LED
    load(0, 8'h5A);
    chk("R2", led, 8'h5A);
    load(1, 8'hC3);
    chk("R2", led, 8'h5A);
    run(3'd0, 2'b11, 0);
    chk("R2", led, 8'hC3);

    // R6 R7 R8 sweep
    for (int k = 0; k < 4; k++) begin
      for (int f = 0; f < 8; f++) begin
        for (int r = 0; r < 4; r++) begin
          a = 8'hA5 ^ 8'(k * 37);
          b = 8'(k * 91 + 3);
          load(0, a);
          load(1, b);
          case (r)
            0: begin ea = op(3'(f), a, b); eb = b; end
            1: begin ea = a; eb = op(3'(f), a, b); end
            2: begin ea = op(3'(f), a, b); eb = ea; end
            default: begin ea = b; eb = a; end
          endcase
          run(3'(f), 2'(r), 0);
          chk(r == 3 ? "R7" : "R6", led, ea);
          run(3'd1, 2'b11, 0);
          chk("R8", led, eb);
        end
      end
    end

    // R4 R5: disturbances mid-run leave result intact
    load(0, 8'hF0);
    load(1, 8'h96);
    run(3'd2, 2'b10, 1);
    chk("R5", led, 8'hF0 ^ 8'h96);
    run(3'd0, 2'b11, 0);
    chk("R5", led, 8'hF0 ^ 8'h96);

    // R4: exec held high after run does not restart
    @(negedge clk);
    exec = 1;
    @(negedge clk);
    chk("R4", {7'd0, busy}, 8'd1);
    repeat (W) @(negedge clk);
    chk("R4", {7'd0, busy}, 8'd0);
    repeat (3) @(negedge clk);
    chk("R4", {7'd0, busy}, 8'd0);
    exec = 0;
    @(negedge clk);
    chk("R4", {7'd0, busy}, 8'd0);

    // R1: asynchronous reset mid-run clears everything
    load(0, 8'h77);
    @(negedge clk);
    exec = 1;
    @(negedge clk);
    exec = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R1", led, '0);
    chk("R1", {7'd0, busy}, 8'd0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule